// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Decade Counter

This block is a 4-bit counter stepped by two separate count clocks, one for counting up and one for counting down, instead of a clock and a direction pin. A parameter picks the modulus. In decade mode the count runs 0 to 9. In binary mode it runs 0 to 15. A level-sensitive clear forces the count to zero. A level-sensitive active-low load copies a 4-bit preset word into the count. Two active-low terminal-count outputs, carry and borrow, let stages be chained. The carry and borrow of one stage drive the up and down count clocks of the next, more significant stage.

The design is synchronous to a free-running system clock. Each count clock passes through a short synchronizer, and its rising edges are detected inside the block. Carry is gated by the low phase of the synchronized up clock, and borrow by the low phase of the synchronized down clock. Each therefore pulses low in the half period before a wrap and returns high in the same system cycle as the wrap. That rising edge is the count edge for the next stage.

Top module: `updn_decade_counter`

## Requirements
- R1: After system reset the count is 0 and carry and borrow are high. While `clr` is high, the count becomes 0 at the next system edge, whatever `load_n`, `preset` and both count clocks are doing.
- R2: While `load_n` is low and `clr` is low, the count takes the value of `preset` at the next system edge. Activity on either count clock has no effect.
- R3: A rising edge on `up_clk` while `dn_clk` is high adds one to the count. The new value appears at the third system edge after the input rises (two synchronizer stages, then the edge detector).
- R4: A rising edge on `dn_clk` while `up_clk` is high subtracts one from the count, with the same latency as R3.
- R5: Counting up wraps from the top value to 0, and counting down wraps from 0 to the top value. The top value is 9 when `DECADE`=1 and 15 when `DECADE`=0. In binary mode the values 10 to 15 count like any other value.
- R6: `carry_n` is low exactly when the count equals the top value and the synchronized up clock is low. It goes high in the same system cycle as the wrap to 0.
- R7: `borrow_n` is low exactly when the count is 0 and the synchronized down clock is low. It goes high in the same system cycle as the wrap to the top value.
- R8: In decade mode, a count in the range 10 to 15 goes to 0 on an up count and to 9 on a down count. While the count is in that range, carry and borrow stay high.
- R9: A count-clock rising edge is ignored, and the count holds, in two cases: the other clock is low, or both clocks rise in the same system cycle.
- R10: A count-clock edge that is detected in the first system cycle after `clr` or `load` is released is ignored. An edge detected one cycle later is counted.
- R11: Two decade stages chained carry-to-up-clock and borrow-to-down-clock count 00 to 99 and wrap to 00 when counting up. They run the same sequence in reverse when counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr | input | 1 | Active-high clear, overrides every other input |
| load_n | input | 1 | Active-low parallel load |
| preset | input | 4 | Value copied into the count during load |
| up_clk | input | 1 | Count-up clock; a rising edge increments |
| dn_clk | input | 1 | Count-down clock; a rising edge decrements |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count when counting up |
| borrow_n | output | 1 | Active-low terminal count when counting down |

## Verification
The assertions check several rules on every cycle:
- clear and load take priority over counting, and load copies the preset;
- the wraps at both ends of the range;
- a decade count never leaves 0 to 9 unless an illegal value is loaded;
- an illegal value returns to 0 or 9 on its first count;
- carry is low only just before a wrap or a hold at the top value;
- the step decision holds in the cycle after a release and when both clocks rise together.

Other behaviour can only be shown by the bench's scenarios: the three-edge count latency, the exact phase of the carry and borrow pulses against the count clocks, and the full 00 to 99 sequence and its reverse through two chained stages.

// File: rtl/udc_pkg.sv
package udc_pkg;

    localparam int CW = 4;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2
    } step_e;

    typedef struct packed {
        logic up_lvl;
        logic dn_lvl;
        logic up_rise;
        logic dn_rise;
    } clk_view_t;

    function automatic cnt_t top_val(input logic dec);
        return dec ? cnt_t'(9) : cnt_t'((1 << CW) - 1);
    endfunction

    function automatic logic is_legal(input cnt_t c, input logic dec);
        return (c <= top_val(dec));
    endfunction

    function automatic cnt_t next_up(input cnt_t c, input logic dec);
        if (!is_legal(c, dec)) return '0;
        if (c == top_val(dec)) return '0;
        return cnt_t'(c + 1'b1);
    endfunction

    function automatic cnt_t next_dn(input cnt_t c, input logic dec);
        if (!is_legal(c, dec)) return top_val(dec);
        if (c == '0) return top_val(dec);
        return cnt_t'(c - 1'b1);
    endfunction

endpackage

// File: rtl/udc_edge_sync.sv
module udc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[LAST-1:0], din};
    end

    assign lvl  = sh[LAST];
    assign rise = sh[LAST-1] & ~sh[LAST];

    // R3: an edge is reported for a single system cycle only
    a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/udc_step_arb.sv
module udc_step_arb
    import udc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl,
    input  clk_view_t view,
    output step_e     step
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= ctrl;
    end

    always_comb begin
        step = ST_HOLD;
        if (!(busy_q || ctrl)) begin
            if (view.up_rise && !view.dn_rise && view.dn_lvl)
                step = ST_UP;
            else if (view.dn_rise && !view.up_rise && view.up_lvl)
                step = ST_DN;
        end
    end

    // R9: coincident edges never produce a step
    a_r9_both_hold: assert property (@(posedge clk) disable iff (rst)
        (view.up_rise && view.dn_rise) |-> step == ST_HOLD);

endmodule

// File: rtl/udc_count_reg.sv
module udc_count_reg
    import udc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  load_n,
    input  cnt_t  preset,
    input  step_e step,
    output cnt_t  q
);
    localparam cnt_t TOP = top_val(DECADE);

    always_ff @(posedge clk) begin
        if (rst || clr)   q <= '0;
        else if (!load_n) q <= preset;
        else begin
            unique case (step)
                ST_UP:   q <= next_up(q, DECADE);
                ST_DN:   q <= next_dn(q, DECADE);
                default: q <= q;
            endcase
        end
    end

    // R5: wrap at both ends of the range
    a_r5_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && step == ST_UP && q == TOP) |=> q == '0);
    a_r5_dn_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n && step == ST_DN && q == '0) |=> q == TOP);

endmodule

// File: rtl/udc_term_out.sv
module udc_term_out
    import udc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  cnt_t q,
    input  logic up_lvl,
    input  logic dn_lvl,
    output logic carry_n,
    output logic borrow_n
);
    localparam cnt_t TOP = top_val(DECADE);

    assign carry_n  = !((q == TOP) && !up_lvl);
    assign borrow_n = !((q == '0) && !dn_lvl);

endmodule

// File: rtl/updn_decade_counter.sv
module updn_decade_counter
    import udc_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load_n,
    input  logic [CW-1:0] preset,
    input  logic          up_clk,
    input  logic          dn_clk,
    output logic [CW-1:0] count,
    output logic          carry_n,
    output logic          borrow_n
);
    localparam cnt_t TOP = top_val(DECADE);

    logic [1:0] raw, lvl, rise;
    clk_view_t  view;
    step_e      step;
    logic       ctrl;

    assign raw  = {dn_clk, up_clk};
    assign ctrl = clr | ~load_n;

    for (genvar g = 0; g < 2; g++) begin : g_sync
        udc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .lvl (lvl[g]),
            .rise(rise[g])
        );
    end

    assign view = '{up_lvl: lvl[0], dn_lvl: lvl[1], up_rise: rise[0], dn_rise: rise[1]};

    udc_step_arb u_arb (
        .clk (clk),
        .rst (rst),
        .ctrl(ctrl),
        .view(view),
        .step(step)
    );

    udc_count_reg #(.DECADE(DECADE)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .load_n(load_n),
        .preset(preset),
        .step  (step),
        .q     (count)
    );

    udc_term_out #(.DECADE(DECADE)) u_term (
        .q       (count),
        .up_lvl  (view.up_lvl),
        .dn_lvl  (view.dn_lvl),
        .carry_n (carry_n),
        .borrow_n(borrow_n)
    );

    // R1: clear wins over everything
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);
    // R2: load copies the preset
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> count == $past(preset));
    // R10: no step in the cycle following a control release
    a_r10_release_hold: assert property (@(posedge clk) disable iff (rst)
        $past(clr || !load_n) |-> step == ST_HOLD);
    // R6: a low carry is followed by a hold at top or a wrap to zero
    a_r6_carry_next: assert property (@(posedge clk) disable iff (rst)
        (!carry_n && !clr && load_n) |=> (count == TOP || count == '0));

    if (DECADE) begin : g_dec_chk
        // R8: a legal decade count stays legal without a load
        a_r8_stay_legal: assert property (@(posedge clk) disable iff (rst)
            (count <= 4'd9 && !clr && load_n) |=> count <= 4'd9);
        // R8: an illegal value recovers on its first count
        a_r8_recover: assert property (@(posedge clk) disable iff (rst)
            (count > 4'd9 && !clr && load_n && step != ST_HOLD) |=>
                (count == 4'd0 || count == 4'd9));
    end

endmodule

// File: tb/updn_decade_counter_test.sv
module updn_decade_counter_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic       lo_clr, lo_load_n, lo_up, lo_dn;
    logic [3:0] lo_pre, lo_q;
    logic       lo_cy, lo_bw;
    logic       hi_clr, hi_load_n;
    logic [3:0] hi_pre, hi_q;
    logic       hi_cy, hi_bw;
    logic       b_clr, b_load_n, b_up, b_dn;
    logic [3:0] b_pre, b_q;
    logic       b_cy, b_bw;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    updn_decade_counter #(.DECADE(1'b1)) uut (
        .clk(clk), .rst(rst), .clr(lo_clr), .load_n(lo_load_n), .preset(lo_pre),
        .up_clk(lo_up), .dn_clk(lo_dn), .count(lo_q), .carry_n(lo_cy), .borrow_n(lo_bw));

    updn_decade_counter #(.DECADE(1'b1)) hi (
        .clk(clk), .rst(rst), .clr(hi_clr), .load_n(hi_load_n), .preset(hi_pre),
        .up_clk(lo_cy), .dn_clk(lo_bw), .count(hi_q), .carry_n(hi_cy), .borrow_n(hi_bw));

    updn_decade_counter #(.DECADE(1'b0)) bin_u (
        .clk(clk), .rst(rst), .clr(b_clr), .load_n(b_load_n), .preset(b_pre),
        .up_clk(b_up), .dn_clk(b_dn), .count(b_q), .carry_n(b_cy), .borrow_n(b_bw));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic lo_load(input int v);
        lo_pre = 4'(v); lo_load_n = 1'b0; tick(1);
        lo_load_n = 1'b1; tick(2);
    endtask

    task automatic lo_up_pulse();
        lo_up = 1'b0; tick(4); lo_up = 1'b1; tick(8);
    endtask

    task automatic lo_dn_pulse();
        lo_dn = 1'b0; tick(4); lo_dn = 1'b1; tick(8);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        lo_clr = 1'b0; lo_load_n = 1'b1; lo_up = 1'b1; lo_dn = 1'b1; lo_pre = 4'd0;
        hi_clr = 1'b0; hi_load_n = 1'b1; hi_pre = 4'd0;
        b_clr = 1'b0; b_load_n = 1'b1; b_up = 1'b1; b_dn = 1'b1; b_pre = 4'd0;
        tick(3);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        chk("R1 reset count", lo_q, 0);
        chk("R1 reset carry", lo_cy, 1);
        chk("R1 reset borrow", lo_bw, 1);
        chk("R1 reset binary count", b_q, 0);

        // R3 latency: third edge after the rise
        lo_up = 1'b0; tick(4);
        lo_up = 1'b1; tick(2);
        chk("R3 not yet counted", lo_q, 0);
        tick(1);
        chk("R3 counted on third edge", lo_q, 1);
        tick(5);

        // R4 down count
        lo_dn_pulse();
        chk("R4 decrement", lo_q, 0);

        // R7 borrow low at zero, R5 wrap down
        lo_dn = 1'b0; tick(4);
        chk("R7 borrow low", lo_bw, 0);
        lo_dn = 1'b1; tick(8);
        chk("R5 wrap down to 9", lo_q, 9);
        chk("R7 borrow high after wrap", lo_bw, 1);

        // R6 carry low at nine, R5 wrap up
        lo_up = 1'b0; tick(4);
        chk("R6 carry low", lo_cy, 0);
        chk("R6 borrow stays high", lo_bw, 1);
        lo_up = 1'b1; tick(8);
        chk("R5 wrap up to 0", lo_q, 0);
        chk("R6 carry high after wrap", lo_cy, 1);

        // R2 load, and load masks counting
        lo_load(7);
        chk("R2 load value", lo_q, 7);
        lo_pre = 4'd3; lo_load_n = 1'b0;
        lo_up_pulse();
        lo_dn_pulse();
        chk("R2 clocks ignored while loading", lo_q, 3);
        lo_load_n = 1'b1; tick(2);

        // R1 clear beats load and clocks
        lo_pre = 4'd5; lo_load_n = 1'b0; lo_clr = 1'b1; lo_up = 1'b0; tick(2);
        chk("R1 clear overrides load", lo_q, 0);
        lo_up = 1'b1; tick(6);
        chk("R1 clear overrides count", lo_q, 0);
        lo_clr = 1'b0; lo_load_n = 1'b1; tick(2);

        // R8 illegal recovery, decade mode
        lo_load(12);
        chk("R8 illegal value loaded", lo_q, 12);
        lo_up = 1'b0; tick(4);
        chk("R8 carry high while illegal", lo_cy, 1);
        lo_up = 1'b1; tick(8);
        chk("R8 up from 12 goes to 0", lo_q, 0);
        lo_load(13);
        lo_dn = 1'b0; tick(4);
        chk("R8 borrow high while illegal", lo_bw, 1);
        lo_dn = 1'b1; tick(8);
        chk("R8 down from 13 goes to 9", lo_q, 9);

        // R10 edge in first cycle after release is dropped
        lo_pre = 4'd5; lo_load_n = 1'b0; tick(1);
        lo_up = 1'b0; tick(4);
        lo_up = 1'b1; tick(2);
        lo_load_n = 1'b1; tick(8);
        chk("R10 edge at release ignored", lo_q, 5);
        lo_load_n = 1'b0; tick(1);
        lo_up = 1'b0; tick(4);
        lo_up = 1'b1; tick(1);
        lo_load_n = 1'b1; tick(8);
        chk("R10 edge one cycle later counted", lo_q, 6);

        // R9 coincident edges and edge with other clock low
        lo_up = 1'b0; lo_dn = 1'b0; tick(4);
        lo_up = 1'b1; lo_dn = 1'b1; tick(8);
        chk("R9 coincident edges hold", lo_q, 6);
        lo_dn = 1'b0; tick(4);
        lo_up = 1'b0; tick(4);
        lo_up = 1'b1; tick(8);
        chk("R9 up edge with down low ignored", lo_q, 6);
        lo_dn = 1'b1; tick(8);
        chk("R4 down edge with up high counts", lo_q, 5);

        // R11 cascade sweep up and back down
        lo_clr = 1'b1; hi_clr = 1'b1; tick(1);
        lo_clr = 1'b0; hi_clr = 1'b0; tick(3);
        chk("R11 cascade start", hi_q * 10 + lo_q, 0);
        for (int v = 0; v < 100; v++) begin
            lo_up = 1'b0; tick(4);
            chk("R6 cascade carry", lo_cy, ((v % 10) == 9) ? 0 : 1);
            lo_up = 1'b1; tick(8);
            chk("R11 cascade up", hi_q * 10 + lo_q, (v + 1) % 100);
        end
        for (int v = 0; v < 100; v++) begin
            lo_dn = 1'b0; tick(4);
            chk("R7 cascade borrow", lo_bw, (((100 - v) % 100) % 10 == 0) ? 0 : 1);
            lo_dn = 1'b1; tick(8);
            chk("R11 cascade down", hi_q * 10 + lo_q, (200 - v - 1) % 100);
        end

        // R5 binary modulus
        for (int v = 0; v < 17; v++) begin
            b_up = 1'b0; tick(4);
            chk("R6 binary carry", b_cy, ((v % 16) == 15) ? 0 : 1);
            b_up = 1'b1; tick(8);
            chk("R5 binary up", b_q, (v + 1) % 16);
        end
        b_clr = 1'b1; tick(1); b_clr = 1'b0; tick(2);
        b_dn = 1'b0; tick(4);
        chk("R7 binary borrow low", b_bw, 0);
        b_dn = 1'b1; tick(8);
        chk("R5 binary wrap down to 15", b_q, 15);
        b_pre = 4'd12; b_load_n = 1'b0; tick(1); b_load_n = 1'b1; tick(2);
        b_up = 1'b0; tick(4); b_up = 1'b1; tick(8);
        chk("R5 binary 12 counts to 13", b_q, 13);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule